// File: doc/BRIEF.md
# Banked Register File Decoder

This block is the data-memory address path and byte storage of a small 8-bit core. Each access names a 7-bit location inside a 128-byte bank. Two bank-select bits pick the bank. The block forms the full 8-bit register-file address from these two inputs and decodes it to one of four targets: general-purpose RAM, the pointer register, a hook towards the other control registers, or nothing.

Location 00h in every bank is a virtual slot, not a register. An access there uses the 8-bit pointer register as the full address instead, so one access can reach either implemented bank. Several control locations appear in both banks. Such a location is reported on the hook at a single bank-0 address, so one physical register serves both banks. The contents of the control registers other than the pointer live outside this block. They are reached through the hook outputs and the `hook_rdata` input.

Reads are combinational from the current inputs. Writes take effect at the rising clock edge. Any location that decodes to nothing reads as zero, and a write to it changes nothing.

Top module: `regfile_bank_dec`

## Requirements
- R1: A direct access with bank bits 00 forms the address {0, offset}. Offsets 20h–7Fh hold 96 read/write RAM bytes.
- R2: With bank bits 01 the address is {1, offset}. Offsets 20h–3Fh (addresses A0h–BFh) hold 32 further RAM bytes, separate from those of bank 0. Offsets 40h–7Fh of bank 1 read zero, and writes to them are ignored.
- R3: Offset 00h in bank 0 or bank 1 is redirected to the full 8-bit address held in the pointer register, so that either bank can be reached whatever the bank bits are.
- R4: The pointer register answers at offset 04h in both banks, both directly and through the redirect. Its value is always shown on `ptr_q`.
- R5: Offsets 02h, 03h, 0Ah and 0Bh address the same control register from both banks. For these, `hook_addr` carries the bank-0 address (bit 7 clear).
- R6: Other implemented control locations are selected on `hook_sel` with their own full address on `hook_addr`. A read there returns `hook_rdata`, and a write raises `hook_wr`. Bank 0 has offsets 01,02,03,05,06,07,0A,0B,0C,0E,0F,10,11,12,15,16,17,1E,1F. Bank 1 has offsets 01,02,03,05,06,07,0A,0B,0C,0E,12,1F.
- R7: Every other address reads zero, and a write there changes no RAM byte, leaves the pointer unchanged and raises no `hook_wr`.
- R8: A redirected access while the pointer holds 00h or 80h reads zero and has no effect when written.
- R9: While bank bit 1 is set, every access, including offset 00h, behaves as an unimplemented location.
- R10: A synchronous active-high reset clears all RAM bytes and the pointer to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 2 | Bank-select bits (bit 1 must be kept clear) |
| acc_addr | input | 7 | Offset within the bank |
| wr_en | input | 1 | Write strobe for the current access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the current access |
| ptr_q | output | 8 | Current pointer register value |
| hook_sel | output | 1 | Access targets an external control register |
| hook_addr | output | 8 | Resolved address of that register (mirrors folded to bank 0) |
| hook_wr | output | 1 | Write strobe towards the external control register |
| hook_rdata | input | 8 | Read data returned by the external control register |

## Verification
A write through the virtual slot while the pointer holds 04h updates the pointer in the same cycle that the redirect is using that pointer. The read in that cycle must still be based on the old pointer, and the next access must follow the new one. The bench provokes this with directed writes and also lets random traffic aim the pointer at itself often. A behavioural model updates its pointer only after comparing, and it judges both the same-cycle read data and the following redirected accesses.

// File: rtl/rfd_pkg.sv
package rfd_pkg;

    parameter int DATA_W     = 8;
    parameter int OFF_W      = 7;
    parameter int BANK_W     = 2;
    localparam int ADDR_W    = OFF_W + 1;
    localparam int RAM_DEPTH = 128;
    localparam int IDX_W     = $clog2(RAM_DEPTH);

    localparam logic [OFF_W-1:0] RAM_LO       = 7'h20;
    localparam logic [OFF_W-1:0] HIGH_RAM_END = 7'h40;
    localparam logic [OFF_W-1:0] HIGH_RAM_BIAS = 7'd64;
    localparam logic [4:0]       PTR_SLOT     = 5'h04;

    // implemented control offsets below 20h, one bit per offset
    localparam logic [31:0] LOW_CTRL_MAP  = 32'hC0E7_DCEE;
    localparam logic [31:0] HIGH_CTRL_MAP = 32'h8004_5CEE;
    // offsets shared by both banks and folded onto bank 0
    localparam logic [31:0] MIRROR_MAP    = 32'h0000_0C0C;

    typedef enum logic [1:0] {
        SLOT_NONE,
        SLOT_GPR,
        SLOT_PTR,
        SLOT_HOOK
    } slot_e;

    typedef struct packed {
        slot_e             slot;
        logic [ADDR_W-1:0] phys;
        logic [IDX_W-1:0]  ram_idx;
    } route_t;

    function automatic route_t classify(input logic [ADDR_W-1:0] a);
        route_t r;
        logic [OFF_W-1:0] lo;
        lo        = a[OFF_W-1:0];
        r.slot    = SLOT_NONE;
        r.phys    = a;
        r.ram_idx = '0;
        if (lo >= RAM_LO) begin
            if (!a[ADDR_W-1]) begin
                r.slot    = SLOT_GPR;
                r.ram_idx = lo - RAM_LO;
            end else if (lo < HIGH_RAM_END) begin
                r.slot    = SLOT_GPR;
                r.ram_idx = lo + HIGH_RAM_BIAS;
            end
        end else if (lo[4:0] == PTR_SLOT) begin
            r.slot = SLOT_PTR;
        end else if (a[ADDR_W-1] ? HIGH_CTRL_MAP[lo[4:0]] : LOW_CTRL_MAP[lo[4:0]]) begin
            r.slot = SLOT_HOOK;
            if (MIRROR_MAP[lo[4:0]]) r.phys = {1'b0, lo};
        end
        return r;
    endfunction

endpackage

// File: rtl/rfd_addr_resolve.sv
module rfd_addr_resolve
    import rfd_pkg::*;
#(
    parameter int OW = OFF_W,
    parameter int BW = BANK_W
) (
    input  logic [BW-1:0]  bank_sel,
    input  logic [OW-1:0]  acc_addr,
    input  logic [OW:0]    ptr,
    output route_t         route
);

    logic          via_ptr;
    logic [OW:0]   eff;

    always_comb begin
        via_ptr = (acc_addr == '0);
        eff     = via_ptr ? ptr : {bank_sel[0], acc_addr};
        route   = classify(eff);
        // upper bank bit set: banks not present
        if (bank_sel[BW-1]) route.slot = SLOT_NONE;
    end

endmodule

// File: rtl/rfd_gpr_store.sv
module rfd_gpr_store
    import rfd_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = RAM_DEPTH,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

    // R1
    ram_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (we ##1 (idx == $past(idx))) |-> (rdata == $past(wdata)));

endmodule

// File: rtl/rfd_ptr_reg.sv
module rfd_ptr_reg
    import rfd_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata;
    end

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/regfile_bank_dec.sv
module regfile_bank_dec
    import rfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [OFF_W-1:0]  acc_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ptr_q,
    output logic              hook_sel,
    output logic [ADDR_W-1:0] hook_addr,
    output logic              hook_wr,
    input  logic [DATA_W-1:0] hook_rdata
);

    route_t            route;
    logic              gpr_we;
    logic              ptr_we;
    logic [DATA_W-1:0] gpr_rdata;

    rfd_addr_resolve u_resolve (
        .bank_sel (bank_sel),
        .acc_addr (acc_addr),
        .ptr      (ptr_q),
        .route    (route)
    );

    always_comb begin
        gpr_we   = wr_en && (route.slot == SLOT_GPR);
        ptr_we   = wr_en && (route.slot == SLOT_PTR);
        hook_sel = (route.slot == SLOT_HOOK);
        hook_wr  = wr_en && hook_sel;
        hook_addr = route.phys;
    end

    rfd_gpr_store u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (gpr_we),
        .idx   (route.ram_idx),
        .wdata (wr_data),
        .rdata (gpr_rdata)
    );

    rfd_ptr_reg u_ptr (
        .clk   (clk),
        .rst   (rst),
        .we    (ptr_we),
        .wdata (wr_data),
        .q     (ptr_q)
    );

    always_comb begin
        unique case (route.slot)
            SLOT_GPR:  rd_data = gpr_rdata;
            SLOT_PTR:  rd_data = ptr_q;
            SLOT_HOOK: rd_data = hook_rdata;
            default:   rd_data = '0;
        endcase
    end

    // R9
    upper_bank_idle_chk: assert property (@(posedge clk) disable iff (rst)
        bank_sel[BANK_W-1] |-> (rd_data == '0 && !hook_sel && !hook_wr));

    // R7
    single_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gpr_we, ptr_we, hook_wr}));

    // R8
    null_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_addr == '0 && ptr_q[OFF_W-1:0] == '0) |-> (rd_data == '0 && !hook_sel));

    // R5
    mirror_fold_chk: assert property (@(posedge clk) disable iff (rst)
        (hook_sel && acc_addr inside {7'h02, 7'h03, 7'h0A, 7'h0B})
            |-> !hook_addr[ADDR_W-1]);

endmodule

// File: tb/regfile_bank_dec_test.sv
`timescale 1ns/100ps
module regfile_bank_dec_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bank_sel;
    logic [6:0] acc_addr;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [7:0] ptr_q;
    logic       hook_sel;
    logic [7:0] hook_addr;
    logic       hook_wr;
    logic [7:0] hook_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    assign hook_rdata = hook_addr ^ 8'hA5;

    regfile_bank_dec uut (
        .clk(clk), .rst(rst), .bank_sel(bank_sel), .acc_addr(acc_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ptr_q(ptr_q),
        .hook_sel(hook_sel), .hook_addr(hook_addr), .hook_wr(hook_wr),
        .hook_rdata(hook_rdata)
    );

    // behavioural reference model
    logic [7:0] m_mem [256];
    logic [7:0] m_ptr;

    // kind: 0 nothing, 1 ram, 2 pointer, 3 hook
    function automatic void m_route(input logic [1:0] b, input logic [6:0] o,
                                    output int kind, output logic [7:0] a,
                                    output logic [7:0] canon);
        kind  = 0;
        a     = (o == 7'h00) ? m_ptr : {b[0], o};
        canon = a;
        if (b[1]) kind = 0;
        else if (o == 7'h00 && (m_ptr == 8'h00 || m_ptr == 8'h80)) kind = 0;
        else if (a == 8'h04 || a == 8'h84) kind = 2;
        else if ((a >= 8'h20 && a <= 8'h7F) || (a >= 8'hA0 && a <= 8'hBF)) kind = 1;
        else if (a inside {8'h01, 8'h02, 8'h03, 8'h05, 8'h06, 8'h07, 8'h0A, 8'h0B,
                           8'h0C, 8'h0E, 8'h0F, 8'h10, 8'h11, 8'h12, 8'h15, 8'h16,
                           8'h17, 8'h1E, 8'h1F}) kind = 3;
        else if (a inside {8'h81, 8'h82, 8'h83, 8'h85, 8'h86, 8'h87, 8'h8A, 8'h8B,
                           8'h8C, 8'h8E, 8'h92, 8'h9F}) begin
            kind = 3;
            if (a inside {8'h82, 8'h83, 8'h8A, 8'h8B}) canon = a - 8'h80;
        end
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] b, input logic [6:0] o, input bit we,
                      input logic [7:0] d, input string ctx);
        int kind;
        logic [7:0] a, canon, exp_rd;
        string tag;
        @(negedge clk);
        bank_sel = b; acc_addr = o; wr_en = we; wr_data = d;
        #1;
        m_route(b, o, kind, a, canon);
        case (kind)
            1: exp_rd = m_mem[a];
            2: exp_rd = m_ptr;
            3: exp_rd = canon ^ 8'hA5;
            default: exp_rd = 8'h00;
        endcase
        if (b[1]) tag = "R9";
        else if (o == 0 && (m_ptr == 8'h00 || m_ptr == 8'h80)) tag = "R8";
        else if (kind == 0) tag = (a[7] && a[6:0] >= 7'h40) ? "R2" : "R7";
        else if (kind == 2) tag = "R4";
        else if (kind == 3) tag = (canon != a) ? "R5" : "R6";
        else tag = a[7] ? "R2" : "R1";
        if (o == 0 && kind != 0) tag = {tag, "/R3"};
        tag = {ctx, tag};
        check(rd_data == exp_rd, tag, "rd_data", rd_data, exp_rd);
        check(hook_sel == (kind == 3) && hook_wr == (we && kind == 3), tag,
              "hook_sel/wr", {hook_sel, hook_wr}, {kind == 3, we && kind == 3});
        if (kind == 3)
            check(hook_addr == canon, tag, "hook_addr", hook_addr, canon);
        check(ptr_q == m_ptr, tag, "ptr_q", ptr_q, m_ptr);
        if (we) begin
            if (kind == 1) m_mem[a] = d;
            else if (kind == 2) m_ptr = d;
        end
    endtask

    task automatic set_ptr(input logic [7:0] v);
        op(2'b00, 7'h04, 1'b1, v, "");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
        m_ptr = 8'h00;
        rst = 1'b1; bank_sel = 2'b00; acc_addr = 7'h00; wr_en = 1'b0; wr_data = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ptr_q == 8'h00, "R10", "ptr_q after reset", ptr_q, 0);
        rst = 1'b0;

        // R10: every direct location reads its reset value
        for (int b = 0; b < 2; b++)
            for (int o = 0; o < 128; o++)
                op(b[1:0], o[6:0], 1'b0, 8'h00, "R10:");

        // R1 / R2 region edges
        op(2'b00, 7'h20, 1'b1, 8'h11, "");
        op(2'b00, 7'h7F, 1'b1, 8'h22, "");
        op(2'b01, 7'h20, 1'b1, 8'h33, "");
        op(2'b01, 7'h3F, 1'b1, 8'h44, "");
        op(2'b01, 7'h40, 1'b1, 8'h55, "");
        op(2'b01, 7'h7F, 1'b1, 8'h66, "");
        op(2'b00, 7'h20, 1'b0, 8'h00, "");
        op(2'b00, 7'h7F, 1'b0, 8'h00, "");
        op(2'b00, 7'h40, 1'b0, 8'h00, "");
        op(2'b01, 7'h20, 1'b0, 8'h00, "");
        op(2'b01, 7'h3F, 1'b0, 8'h00, "");
        op(2'b01, 7'h40, 1'b0, 8'h00, "");

        // R4 pointer from both banks
        op(2'b01, 7'h04, 1'b1, 8'hA7, "");
        op(2'b00, 7'h04, 1'b0, 8'h00, "");
        // R3 redirect into bank 1 from bank 0 and back
        op(2'b00, 7'h00, 1'b1, 8'h5C, "");
        op(2'b01, 7'h27, 1'b0, 8'h00, "");
        set_ptr(8'h30);
        op(2'b01, 7'h00, 1'b1, 8'h9E, "");
        op(2'b00, 7'h30, 1'b0, 8'h00, "");
        // R5 / R6 hook from both banks
        op(2'b01, 7'h03, 1'b1, 8'h01, "");
        op(2'b00, 7'h0B, 1'b0, 8'h00, "");
        op(2'b01, 7'h12, 1'b1, 8'h02, "");
        set_ptr(8'h8A);
        op(2'b00, 7'h00, 1'b0, 8'h00, "");
        // R7 holes
        op(2'b00, 7'h08, 1'b1, 8'hFF, "");
        op(2'b01, 7'h0F, 1'b1, 8'hFF, "");
        // R8 null pointer
        set_ptr(8'h80);
        op(2'b00, 7'h00, 1'b1, 8'h77, "");
        op(2'b01, 7'h00, 1'b0, 8'h00, "");
        set_ptr(8'h00);
        op(2'b01, 7'h00, 1'b1, 8'h78, "");
        // same cycle: redirect writes the pointer itself
        set_ptr(8'h84);
        op(2'b00, 7'h00, 1'b1, 8'h2A, "");
        op(2'b00, 7'h00, 1'b0, 8'h00, "");
        set_ptr(8'h04);
        op(2'b01, 7'h00, 1'b1, 8'hB1, "");
        op(2'b00, 7'h00, 1'b1, 8'h99, "");
        // R9 upper bank bit
        op(2'b10, 7'h00, 1'b1, 8'h13, "");
        op(2'b11, 7'h04, 1'b1, 8'h13, "");
        op(2'b10, 7'h20, 1'b1, 8'h13, "");
        op(2'b11, 7'h03, 1'b1, 8'h13, "");
        op(2'b00, 7'h20, 1'b0, 8'h00, "");

        // random traffic, pointer often aimed at itself or the slot
        for (int n = 0; n < 6000; n++) begin
            logic [1:0] b;
            logic [6:0] o;
            logic [7:0] d;
            int r;
            r = $urandom_range(0, 99);
            b = (r < 5) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
            if (r < 25)      o = 7'h00;
            else if (r < 35) o = 7'h04;
            else if (r < 60) o = 7'($urandom_range(0, 31));
            else             o = 7'($urandom_range(0, 127));
            d = 8'($urandom_range(0, 255));
            if (r >= 95) d = {1'($urandom_range(0, 1)), 7'($urandom_range(0, 5))};
            op(b, o, ($urandom_range(0, 1) == 1), d, "");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule